// File: doc/BRIEF.md
# Triggered Pre-Capture Sample FIFO

This block stores three-axis sensor samples in a 32-deep buffer. It is meant for cases where the host wants the history that led up to an event, not only what followed it. Each 48-bit sample packs X in bits 15:0, Y in bits 31:16 and Z in bits 47:32, so a byte-wise read starts with X low. A host pops samples through a show-ahead read port: the oldest stored sample is always on `popData`. It polls a status word holding the fill count and four flags. One interrupt line carries either a per-sample data-ready pulse or the overrun level. A second line carries the watermark level.

Two operating modes exist. In plain streaming the buffer keeps filling, and once it is full each new sample pushes out the oldest one. In freeze-on-trigger mode a sample presented with `trigger` high marks the event. If the buffer was already full, one further sample is stored and then writing stops. The retained window is therefore thirty older samples, the event sample and one later sample. If the buffer is still filling, writing stops as soon as a sample presented with `trigger` high completes the fill.

Top module: `capture_fifo`

## Requirements
- R1: Samples leave in arrival order. `popData` shows the oldest stored sample, and a pop (`popReq` high with count nonzero) removes it at the clock edge.
- R2: The status word holds the count (0..32) in bits 5:0, empty in bit 6, overrun in bit 7, watermark in bit 8 and frozen in bit 9. After reset it reads 0x040.
- R3: In streaming mode a sample written while the buffer holds 32 entries replaces the oldest one. The count stays 32 and overrun (bit 7) is 1 whenever the count is 32.
- R4: In freeze mode a triggered sample that arrives while the buffer is full is stored, and so is exactly one more sample. Then frozen (bit 9) is set and the buffer holds 30 earlier samples, the trigger sample and the next sample, in order.
- R5: In freeze mode, while the buffer is not full, a triggered sample that leaves the count below 32 causes no freeze. A triggered sample that brings the count to 32 freezes at once.
- R6: While frozen, incoming samples are ignored. Popping still works, and the pop that empties the buffer clears frozen so that collection resumes.
- R7: The watermark flag and `wmIrq` are high exactly when the count is greater than the 5-bit `threshold`. With a threshold of 31 they mean the buffer is full.
- R8: With `irqSel` = 0, `irqOut` pulses high for one cycle after each accepted sample. With `irqSel` = 1, `irqOut` follows the overrun flag.
- R9: Driving `enable` low, or changing `freezeMode`, empties the buffer and clears overrun, frozen and any pending freeze. No sample or pop is accepted in that cycle.
- R10: A pop and a write in the same cycle are both honoured. The count is unchanged and the popped entry is the previous head.
- R11: A pop while the buffer is empty is ignored: the count stays 0 and later samples are not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Buffer enable; low clears everything |
| freezeMode | input | 1 | 0 = streaming, 1 = freeze on trigger |
| threshold | input | 5 | Watermark threshold |
| irqSel | input | 1 | 0 = data-ready pulse, 1 = overrun level on irqOut |
| sampleValid | input | 1 | New sample present this cycle |
| sampleIn | input | 48 | Sample {Z, Y, X}, 16 bits per axis |
| trigger | input | 1 | Marks the sample presented this cycle as the event |
| popReq | input | 1 | Remove the head sample |
| popData | output | 48 | Oldest stored sample |
| status | output | 10 | {frozen, watermark, overrun, empty, count[5:0]} |
| irqOut | output | 1 | Selected interrupt |
| wmIrq | output | 1 | Watermark interrupt level |

## Verification
The bench aims at the freeze window. It checks that a triggered sample arriving at full depth leaves exactly the samples from the third-oldest through the post-trigger sample. A design that froze on the trigger itself would lose the post-trigger sample, and one that froze a sample late would lose one more old sample. It also checks that an early trigger during fill does not freeze a partly filled buffer, and that a sample arriving while frozen neither advances the count nor appears after draining. It further probes overwrite at full depth, a simultaneous pop and write, a pop on an empty buffer, and the clearing caused by a mode change. Each of these would show up as a wrong head sample or a wrong count if the pointer or count bookkeeping slipped.

// File: rtl/capfifo_pkg.sv
package capfifo_pkg;
  typedef struct packed {
    logic wrEn;
    logic rdAdv;
    logic clear;
  } capfifoStrobe_t;
endpackage

// File: rtl/capfifo_dp.sv
module capfifo_dp
  import capfifo_pkg::*;
#(
  parameter int DEPTH    = 32,
  parameter int SAMPLE_W = 48
) (
  input  logic                clk,
  input  logic                rst_n,
  input  capfifoStrobe_t      strobe,
  input  logic [SAMPLE_W-1:0] wrData,
  output logic [SAMPLE_W-1:0] rdData
);
  localparam int AW = $clog2(DEPTH);

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.wrEn && !strobe.clear) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.wrEn)  wrPtr <= nextPtr(wrPtr);
      if (strobe.rdAdv) rdPtr <= nextPtr(rdPtr);
    end
  end

  assign rdData = mem[rdPtr];

  // R9: a clear returns both pointers to the origin
  assert_ptr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clear |=> (wrPtr == '0 && rdPtr == '0));

  // R10: a write together with a head advance moves both pointers by one
  assert_ptr_lockstep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && strobe.rdAdv && !strobe.clear) |=>
      (wrPtr - rdPtr == $past(wrPtr - rdPtr)));
endmodule

// File: rtl/capfifo_ctrl.sv
module capfifo_ctrl
  import capfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int THR_W = 5,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             freezeMode,
  input  logic [THR_W-1:0] threshold,
  input  logic             irqSel,
  input  logic             sampleValid,
  input  logic             trigger,
  input  logic             popReq,
  output capfifoStrobe_t   strobe,
  output logic [CNT_W+3:0] status,
  output logic             irqOut,
  output logic             wmIrq
);
  logic [CNT_W-1:0] cnt, cntNext;
  logic frozen, armed, ovrFlag, drdyPulse, prevMode;
  logic fullNow, emptyNow, clearReq, popEff, accept, dropOld, wmFlag;

  always_comb begin
    fullNow  = (cnt == CNT_W'(DEPTH));
    emptyNow = (cnt == '0);
    clearReq = !enable || (freezeMode != prevMode);
    popEff   = !clearReq && popReq && !emptyNow;
    accept   = !clearReq && sampleValid && !frozen;
    dropOld  = accept && fullNow && !popEff;
    cntNext  = cnt + CNT_W'(accept && !dropOld) - CNT_W'(popEff);
    wmFlag   = (cnt > CNT_W'(threshold));
    strobe.wrEn  = accept;
    strobe.rdAdv = popEff || dropOld;
    strobe.clear = clearReq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      frozen    <= 1'b0;
      armed     <= 1'b0;
      ovrFlag   <= 1'b0;
      drdyPulse <= 1'b0;
      prevMode  <= 1'b0;
    end else begin
      prevMode <= freezeMode;
      if (clearReq) begin
        cnt       <= '0;
        frozen    <= 1'b0;
        armed     <= 1'b0;
        ovrFlag   <= 1'b0;
        drdyPulse <= 1'b0;
      end else begin
        cnt       <= cntNext;
        ovrFlag   <= (cntNext == CNT_W'(DEPTH));
        drdyPulse <= accept;
        if (frozen && popEff && cnt == CNT_W'(1)) begin
          frozen <= 1'b0;
          armed  <= 1'b0;
        end else if (accept && freezeMode) begin
          if (armed) begin
            frozen <= 1'b1;
            armed  <= 1'b0;
          end else if (trigger && fullNow) begin
            armed <= 1'b1;
          end else if (trigger && cntNext == CNT_W'(DEPTH)) begin
            frozen <= 1'b1;
          end
        end
      end
    end
  end

  assign status = {frozen, wmFlag, ovrFlag, emptyNow, cnt};
  assign irqOut = irqSel ? ovrFlag : drdyPulse;
  assign wmIrq  = wmFlag;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  assert_full_overwrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fullNow) |=> (cnt == CNT_W'(DEPTH) && ovrFlag));

  assert_post_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && armed) |=> frozen);

  assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !clearReq && !popEff) |=> (cnt == $past(cnt)));

  assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clearReq |=> (cnt == '0 && !frozen && !ovrFlag));

  assert_empty_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (popReq && emptyNow && !accept) |=> (cnt == '0));
endmodule

// File: rtl/capture_fifo.sv
module capture_fifo
  import capfifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int AXIS_W = 16,
  parameter int AXES   = 3,
  parameter int THR_W  = 5,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   freezeMode,
  input  logic [THR_W-1:0]       threshold,
  input  logic                   irqSel,
  input  logic                   sampleValid,
  input  logic [AXIS_W*AXES-1:0] sampleIn,
  input  logic                   trigger,
  input  logic                   popReq,
  output logic [AXIS_W*AXES-1:0] popData,
  output logic [CNT_W+3:0]       status,
  output logic                   irqOut,
  output logic                   wmIrq
);
  localparam int SAMPLE_W = AXIS_W * AXES;

  capfifoStrobe_t strobe;

  capfifo_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .freezeMode(freezeMode),
    .threshold(threshold), .irqSel(irqSel), .sampleValid(sampleValid),
    .trigger(trigger), .popReq(popReq), .strobe(strobe), .status(status),
    .irqOut(irqOut), .wmIrq(wmIrq)
  );

  capfifo_dp #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(sampleIn),
    .rdData(popData)
  );
endmodule

// File: tb/capture_fifo_test.sv
`timescale 1ns/1ps
module capture_fifo_test;
  logic clk = 0, rst_n = 0;
  logic enable = 1, freezeMode = 0, irqSel = 0, sampleValid = 0, trigger = 0, popReq = 0;
  logic [4:0] threshold = 5'd31;
  logic [47:0] sampleIn = '0, popData;
  logic [9:0] status;
  logic irqOut, wmIrq;
  int checks = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  capture_fifo uut (.*);

  function automatic logic [47:0] smp(int n);
    return {16'h2000 + 16'(n), 16'h1000 + 16'(n), 16'(n)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask

  task automatic push(int n, logic trg);
    sampleValid = 1; sampleIn = smp(n); trigger = trg;
    cyc();
    sampleValid = 0; trigger = 0;
  endtask

  task automatic popChk(string req, int n);
    chk(req, popData, smp(n));
    popReq = 1; cyc(); popReq = 0;
  endtask

  task automatic setMode(logic m); freezeMode = m; cyc(); endtask

  task automatic t_reset();
    chk("R2 reset status", status, 10'h040);
    chk("R8 reset irq", irqOut, 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) push(i, 0);
    chk("R2 count 5", status, 10'h005);
    chk("R1 X in low bits", popData[15:0], 16'h0000);
    for (int i = 0; i < 5; i++) popChk("R1 order", i);
    chk("R2 empty again", status, 10'h040);
  endtask

  task automatic t_empty_pop();
    popReq = 1; cyc(); popReq = 0;
    chk("R11 empty pop count", status, 10'h040);
    push(7, 0);
    chk("R11 later sample kept", status, 10'h001);
    popChk("R11 later sample data", 7);
  endtask

  task automatic t_drdy();
    irqSel = 0;
    sampleValid = 1; sampleIn = smp(9); cyc(); sampleValid = 0;
    chk("R8 data-ready pulse high", irqOut, 1);
    cyc();
    chk("R8 data-ready pulse low", irqOut, 0);
    popChk("R8 drain", 9);
  endtask

  task automatic t_watermark();
    threshold = 5'd3;
    for (int i = 0; i < 3; i++) push(i, 0);
    chk("R7 at threshold", wmIrq, 0);
    push(3, 0);
    chk("R7 above threshold", wmIrq, 1);
    chk("R7 status wm bit", status[8], 1);
    popChk("R7 pop", 0);
    chk("R7 back to threshold", wmIrq, 0);
    for (int i = 1; i < 4; i++) popChk("R7 drain", i);
    threshold = 5'd31;
  endtask

  task automatic t_stream();
    irqSel = 1;
    for (int i = 0; i < 31; i++) push(i, 0);
    chk("R7 thr31 not full", wmIrq, 0);
    push(31, 0);
    chk("R3 full status", status, 10'h1A0);
    chk("R8 overrun on irq", irqOut, 1);
    for (int i = 32; i < 40; i++) push(i, 0);
    chk("R3 still full", status[5:0], 6'd32);
    chk("R3 oldest dropped", popData, smp(8));
    // R10 simultaneous pop and write at full
    sampleValid = 1; sampleIn = smp(40); popReq = 1;
    cyc(); sampleValid = 0; popReq = 0;
    chk("R10 count kept at full", status[5:0], 6'd32);
    chk("R10 head advanced", popData, smp(9));
    popChk("R3 pop", 9);
    chk("R8 overrun cleared", irqOut, 0);
    // R10 simultaneous below full
    sampleValid = 1; sampleIn = smp(41); popReq = 1;
    cyc(); sampleValid = 0; popReq = 0;
    chk("R10 count unchanged", status[5:0], 6'd31);
    for (int i = 11; i < 42; i++) popChk("R10 order", i);
    chk("R10 empty", status, 10'h040);
    irqSel = 0;
  endtask

  task automatic t_freeze_full();
    setMode(1);
    for (int i = 0; i < 32; i++) push(i, 0);
    chk("R4 full not frozen", status[9], 0);
    push(32, 1);
    chk("R4 trigger sample stored, not frozen", status[9], 0);
    push(33, 0);
    chk("R4 frozen after post sample", status, 10'h3A0);
    push(34, 0);
    chk("R6 ignored while frozen", status[5:0], 6'd32);
    for (int i = 2; i < 34; i++) popChk("R4 window", i);
    chk("R6 unfrozen when drained", status, 10'h040);
    push(50, 0);
    chk("R6 resumes collecting", status[5:0], 6'd1);
    popChk("R6 resumed data", 50);
  endtask

  task automatic t_freeze_fill();
    for (int i = 0; i < 10; i++) push(i, i == 3);
    chk("R5 early trigger no freeze", status[9], 0);
    for (int i = 10; i < 31; i++) push(i, 0);
    push(31, 1);
    chk("R5 freeze on fill", status, 10'h3A0);
    push(99, 0);
    chk("R6 frozen head", popData, smp(0));
    chk("R6 frozen count", status[5:0], 6'd32);
  endtask

  task automatic t_clear();
    setMode(0);
    chk("R9 mode change clears", status, 10'h040);
    for (int i = 0; i < 3; i++) push(i, 0);
    enable = 0; cyc();
    chk("R9 disable clears", status, 10'h040);
    enable = 1; cyc();
    push(60, 0);
    popChk("R9 after re-enable", 60);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_empty_pop();
    t_drdy();
    t_watermark();
    t_stream();
    t_freeze_full();
    t_freeze_fill();
    t_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule